// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Multistage Switch

This block connects N = 2^n source ports to N sink ports through n columns of two-by-two steering elements, with N/2 elements per column and (N/2)·n elements in all. A fixed perfect-shuffle wiring sits in front of every column: the wire leaving position q arrives at the position whose index is q rotated left by one bit. Each source port offers a valid flag, an n-bit destination index and a payload. Routing is done by the elements themselves. The element in column s looks only at destination bit n-1-s, so the most significant bit is used first. A 0 sends the packet to the element's upper output and a 1 sends it to the lower output.

Only one path exists between any source and any sink. Two packets can therefore need the same element output even when their final sinks differ. When that happens the packet on the element's upper input keeps the output. The packet on the lower input is discarded, and a blocked flag is raised for the source port it came from. The routing fabric is purely combinational. Delivered packets and blocked flags are captured in output registers, so results appear one clock after the inputs are sampled. The block has no buffering and no retry: a source whose flag is raised must offer its packet again in a later cycle.

Top module: `omega_net`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `out_valid` and `out_blocked` are all zero, whatever the inputs are.
- R2: Outputs are registered. Inputs sampled at a rising edge produce their result just after that edge, and the result lasts only one cycle. A cycle with no valid input that follows a busy cycle shows all outputs idle.
- R3: Every valid packet that is not blocked appears on the output port whose index equals its destination, with its payload unchanged. Every output that receives no packet shows valid 0.
- R4: When all N inputs are valid and input i is addressed to output i, no input is blocked and every output i carries the payload of input i.
- R5: Before each column, position q moves to position rotl(q) within n bits. Column s steers by destination bit n-1-s: 0 selects the even (upper) output and 1 selects the odd (lower) output. With N = 8, a single packet from input 5 addressed to 2 arrives on output 2.
- R6: When both inputs of one element want the same output, the packet on the even (upper) input wins and the other packet is dropped, with `out_blocked` set at its source index. With N = 8, inputs 0 and 4 meet at column 0, element 0. If both destinations have MSB 0, input 4 is blocked and input 0 is delivered.
- R7: An input with valid 0 never causes a conflict and never has its blocked flag set. An output that carries no packet has data 0.
- R8: In every result cycle, the number of valid outputs plus the number of blocked flags equals the number of valid inputs from the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-source packet present |
| in_dest | input | N x log2(N) | Per-source destination index |
| in_data | input | N x W | Per-source payload |
| out_valid | output | N | Per-sink packet delivered (registered) |
| out_data | output | N x W | Per-sink payload, 0 when idle (registered) |
| out_blocked | output | N | Per-source packet dropped by a conflict (registered) |

## Verification
The identity pattern is checked against values written by hand and must show no blocking at all. Random full permutations, which do block on this network, are checked against a path-tracing reference, and this separates correct shuffle and bit-order wiring from a wrong one. Partial masks and random destinations that are not permutations are used to check the arbitration and the handling of idle inputs. Directed pairs are used too: inputs 0 and 4 colliding at the first column, and the same pair with input 4 invalid. These tell upper-wins from lower-wins and show that invalid inputs cause no conflict.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle position: rotate a width-aw index left by one bit.
  function automatic int shuffle_idx(int q, int aw);
    int m;
    m = (1 << aw) - 1;
    return ((q << 1) | (q >> (aw - 1))) & m;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int AW  = 3,
  parameter int W   = 16,
  parameter int SEL = 0
) (
  input  logic                  up_v,
  input  logic [AW-1:0]         up_dest,
  input  logic [W-1:0]          up_data,
  input  logic [AW-1:0]         up_src,
  input  logic                  lo_v,
  input  logic [AW-1:0]         lo_dest,
  input  logic [W-1:0]          lo_data,
  input  logic [AW-1:0]         lo_src,
  output logic [1:0]            o_v,
  output logic [1:0][AW-1:0]    o_dest,
  output logic [1:0][W-1:0]     o_data,
  output logic [1:0][AW-1:0]    o_src,
  output logic                  lo_drop
);

  logic ub, lb;
  assign ub = up_dest[SEL];
  assign lb = lo_dest[SEL];

  // The upper input is placed first; the lower input loses any clash.
  always_comb begin
    o_v     = '0;
    o_dest  = '0;
    o_data  = '0;
    o_src   = '0;
    lo_drop = 1'b0;
    if (up_v) begin
      o_v[ub]    = 1'b1;
      o_dest[ub] = up_dest;
      o_data[ub] = up_data;
      o_src[ub]  = up_src;
    end
    if (lo_v) begin
      if (up_v && (ub == lb)) begin
        lo_drop = 1'b1;
      end else begin
        o_v[lb]    = 1'b1;
        o_dest[lb] = lo_dest;
        o_data[lb] = lo_data;
        o_src[lb]  = lo_src;
      end
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int W     = 16,
  parameter int STAGE = 0,
  localparam int AW   = $clog2(N)
) (
  input  logic [N-1:0]          in_v,
  input  logic [N-1:0][AW-1:0]  in_dest,
  input  logic [N-1:0][W-1:0]   in_data,
  input  logic [N-1:0][AW-1:0]  in_src,
  output logic [N-1:0]          out_v,
  output logic [N-1:0][AW-1:0]  out_dest,
  output logic [N-1:0][W-1:0]   out_data,
  output logic [N-1:0][AW-1:0]  out_src,
  output logic [N-1:0]          kill
);

  localparam int HALF = N / 2;
  localparam int SEL  = AW - 1 - STAGE;

  logic [N-1:0]          sh_v;
  logic [N-1:0][AW-1:0]  sh_dest;
  logic [N-1:0][W-1:0]   sh_data;
  logic [N-1:0][AW-1:0]  sh_src;
  logic [HALF-1:0]       drop;

  // Fixed shuffle wiring in front of this column.
  for (genvar q = 0; q < N; q++) begin : g_shuf
    localparam int P = shuffle_idx(q, AW);
    assign sh_v[P]    = in_v[q];
    assign sh_dest[P] = in_dest[q];
    assign sh_data[P] = in_data[q];
    assign sh_src[P]  = in_src[q];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_sw
    omega_switch #(.AW(AW), .W(W), .SEL(SEL)) u_sw (
      .up_v    (sh_v[2*j]),
      .up_dest (sh_dest[2*j]),
      .up_data (sh_data[2*j]),
      .up_src  (sh_src[2*j]),
      .lo_v    (sh_v[2*j+1]),
      .lo_dest (sh_dest[2*j+1]),
      .lo_data (sh_data[2*j+1]),
      .lo_src  (sh_src[2*j+1]),
      .o_v     (out_v[2*j+1:2*j]),
      .o_dest  (out_dest[2*j+1:2*j]),
      .o_data  (out_data[2*j+1:2*j]),
      .o_src   (out_src[2*j+1:2*j]),
      .lo_drop (drop[j])
    );
  end

  // Map each dropped packet back to the source port it entered on.
  always_comb begin
    kill = '0;
    for (int j = 0; j < HALF; j++) begin
      if (drop[j]) kill[sh_src[2*j+1]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N   = 8,
  parameter int W   = 16,
  localparam int AW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          in_valid,
  input  logic [N-1:0][AW-1:0]  in_dest,
  input  logic [N-1:0][W-1:0]   in_data,
  output logic [N-1:0]          out_valid,
  output logic [N-1:0][W-1:0]   out_data,
  output logic [N-1:0]          out_blocked
);

  logic [N-1:0]          st_v    [AW+1];
  logic [N-1:0][AW-1:0]  st_dest [AW+1];
  logic [N-1:0][W-1:0]   st_data [AW+1];
  logic [N-1:0][AW-1:0]  st_src  [AW+1];
  logic [N-1:0]          st_kill [AW];
  logic [N-1:0]          blk_c;
  logic                  id_c;

  assign st_v[0]    = in_valid;
  assign st_dest[0] = in_dest;
  assign st_data[0] = in_data;
  for (genvar i = 0; i < N; i++) begin : g_tag
    assign st_src[0][i] = AW'(i);
  end

  for (genvar s = 0; s < AW; s++) begin : g_col
    omega_stage #(.N(N), .W(W), .STAGE(s)) u_stage (
      .in_v     (st_v[s]),
      .in_dest  (st_dest[s]),
      .in_data  (st_data[s]),
      .in_src   (st_src[s]),
      .out_v    (st_v[s+1]),
      .out_dest (st_dest[s+1]),
      .out_data (st_data[s+1]),
      .out_src  (st_src[s+1]),
      .kill     (st_kill[s])
    );
  end

  always_comb begin
    blk_c = '0;
    for (int s = 0; s < AW; s++) blk_c = blk_c | st_kill[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= '0;
      out_data    <= '0;
      out_blocked <= '0;
    end else begin
      out_valid   <= st_v[AW];
      out_data    <= st_data[AW];
      out_blocked <= blk_c;
    end
  end

  // Identity pattern detector, used only by the check below.
  always_comb begin
    id_c = &in_valid;
    for (int i = 0; i < N; i++) begin
      if (in_dest[i] != AW'(i)) id_c = 1'b0;
    end
  end

  // Packets leaving the last column must sit on their addressed port,
  // and a delivered packet's source must not also be flagged.
  always_comb begin
    if (!rst) begin
      for (int k = 0; k < N; k++) begin
        if (st_v[AW][k]) begin
          assert_route_dest_R3: assert (st_dest[AW][k] == AW'(k))
            else $error("packet on port %0d carries dest %0d", k, st_dest[AW][k]);
          assert_winner_clear_R3: assert (!blk_c[st_src[AW][k]])
            else $error("delivered source %0d also flagged", st_src[AW][k]);
        end
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && out_blocked == '0));

  assert_conserve_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($countones(out_valid) + $countones(out_blocked))
                     == $past($countones(in_valid))));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) == '0) |-> (out_valid == '0 && out_blocked == '0));

  assert_flag_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((out_blocked & ~$past(in_valid)) == '0));

  assert_identity_free_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(id_c)) |-> (out_blocked == '0 && out_valid == '1));

endmodule

// File: tb/omega_net_tb.sv
`timescale 1ns/1ps
module omega_net_tb;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]          in_valid;
  logic [N-1:0][AW-1:0]  in_dest;
  logic [N-1:0][W-1:0]   in_data;
  logic [N-1:0]          out_valid;
  logic [N-1:0][W-1:0]   out_data;
  logic [N-1:0]          out_blocked;

  omega_net #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_blocked(out_blocked)
  );

  typedef struct {
    logic [N-1:0]        ev;
    logic [N-1:0]        eblk;
    logic [N-1:0][W-1:0] edata;
    string               tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference: follow each packet's position column by column.
  function automatic void model(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] d,
                                input logic [N-1:0][W-1:0] dat, output logic [N-1:0] ov,
                                output logic [N-1:0] ob, output logic [N-1:0][W-1:0] od);
    int pos[N];
    int np[N];
    bit alive[N];
    bit kill[N];
    ov = '0; ob = '0; od = '0;
    for (int i = 0; i < N; i++) begin pos[i] = i; alive[i] = v[i]; end
    for (int s = 0; s < AW; s++) begin
      for (int i = 0; i < N; i++) begin
        pos[i] = ((pos[i] << 1) | (pos[i] >> (AW - 1))) & (N - 1);
        np[i]  = (pos[i] & ~1) | int'(d[i][AW-1-s]);
        kill[i] = 1'b0;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && alive[i] && alive[j] && (pos[i] >> 1) == (pos[j] >> 1)
              && (pos[j] & 1) == 0 && np[i] == np[j]) kill[i] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (kill[i]) begin alive[i] = 1'b0; ob[i] = 1'b1; end
        pos[i] = np[i];
      end
    end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin ov[pos[i]] = 1'b1; od[pos[i]] = dat[i]; end
  endfunction

  task automatic push_item(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] d,
                           input logic [N-1:0][W-1:0] dat, input logic [N-1:0] ev,
                           input logic [N-1:0] eblk, input logic [N-1:0][W-1:0] edata,
                           input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_dest = d; in_data = dat;
    e.ev = ev; e.eblk = eblk; e.edata = edata; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic send(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] d,
                      input logic [N-1:0][W-1:0] dat, input string tag);
    logic [N-1:0] ov, ob;
    logic [N-1:0][W-1:0] od;
    model(v, d, dat, ov, ob, od);
    push_item(v, d, dat, ov, ob, od, tag);
  endtask

  function automatic logic [N-1:0][W-1:0] rand_data();
    logic [N-1:0][W-1:0] r;
    for (int i = 0; i < N; i++) r[i] = W'($urandom);
    return r;
  endfunction

  function automatic logic [N-1:0][AW-1:0] rand_perm();
    int p[N];
    int t, j;
    logic [N-1:0][AW-1:0] r;
    for (int i = 0; i < N; i++) p[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      j = int'($urandom_range(i, 0)); t = p[i]; p[i] = p[j]; p[j] = t;
    end
    for (int i = 0; i < N; i++) r[i] = AW'(p[i]);
    return r;
  endfunction

  // Monitor: one expected item per driven cycle, compared just after the edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(out_valid == e.ev, e.tag, "out_valid", 128'(out_valid), 128'(e.ev));
        check(out_blocked == e.eblk, e.tag, "out_blocked", 128'(out_blocked), 128'(e.eblk));
        for (int k = 0; k < N; k++)
          check(out_data[k] == e.edata[k], e.tag, $sformatf("out_data[%0d]", k),
                128'(out_data[k]), 128'(e.edata[k]));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired with %0d items pending", sb.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0][AW-1:0] d;
    logic [N-1:0][W-1:0]  dat, ed;
    in_valid = '1;
    in_dest  = '0;
    in_data  = '1;
    // R1: outputs stay idle while reset is held with busy inputs.
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == '0, "R1", "out_valid in reset", 128'(out_valid), 128'(0));
    check(out_blocked == '0, "R1", "out_blocked in reset", 128'(out_blocked), 128'(0));
    @(negedge clk);
    rst = 1'b0;
    in_valid = '0;

    // R4: identity, expected values written directly.
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) d[i] = AW'(i);
      dat = rand_data();
      push_item('1, d, dat, '1, '0, dat, "R4");
    end
    // R2: idle cycle right after a busy one.
    push_item('0, d, dat, '0, '0, '0, "R2/R7");

    // R6: inputs 0 and 4 clash at column 0; upper (input 0) wins.
    d = '0; dat = rand_data(); ed = '0;
    d[0] = 3'd0; d[4] = 3'd1; ed[0] = dat[0];
    push_item(8'h11, d, dat, 8'h01, 8'h10, ed, "R6");
    d[0] = 3'd1; d[4] = 3'd0; ed = '0; ed[1] = dat[0];
    push_item(8'h11, d, dat, 8'h02, 8'h10, ed, "R6");
    // R7: same pair with input 4 invalid causes no clash.
    d[0] = 3'd0; d[4] = 3'd0; ed = '0; ed[0] = dat[0];
    push_item(8'h01, d, dat, 8'h01, 8'h00, ed, "R7");
    // R5: lone packet from input 5 to output 2.
    d = '0; d[5] = 3'd2; ed = '0; ed[2] = dat[5];
    push_item(8'h20, d, dat, 8'h04, 8'h00, ed, "R5");

    // R3/R5/R6/R8: random full permutations against the path model.
    for (int r = 0; r < 40; r++) send('1, rand_perm(), rand_data(), "R3/R5/R6/R8");
    // Partial masks on permutations.
    for (int r = 0; r < 40; r++) send(N'($urandom), rand_perm(), rand_data(), "R3/R7");
    // Random destinations, shared sinks allowed.
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++) d[i] = AW'($urandom);
      send(N'($urandom), d, rand_data(), "R6/R8");
    end
    push_item('0, d, dat, '0, '0, '0, "R2");

    repeat (4) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule